// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix-Vector Engine

This block multiplies an incoming vector of 8-bit values by a square matrix of 8-bit weights. The weights are held in a grid of N×N multiply-add cells. Weight rows arrive on a stream and pass through a small queue. From the queue they shift down from the top edge of the grid, one row per clock, until every cell holds its own weight. Those weights stay in place for all later vectors, until the next load replaces them.

Each activation vector enters at the left edge. Row r of the vector is delayed by r clocks, so the operands meet the partial sums as a diagonal wave. Every cell adds its product to the sum coming from above and passes the vector element to its right neighbour. Finished column sums leave the bottom edge and enter a row of per-column accumulators. Each accumulator either replaces its stored sum or adds to it, which lets a caller build a result over several tiles. Each vector carries its own choice between signed and unsigned operands, and its own choice between overwrite and accumulate. Vectors may follow one another on every clock.

Top module: `wsmm_top`

## Requirements
- R1: After a synchronous reset, `res_valid` is all zero, every field of `res_vec` is zero, `load_done` is low and `w_ready` is high.
- R2: Each accepted weight beat (`w_valid` and `w_ready` both high) carries one row of weights. Byte c of the beat (bits c*8+7..c*8) is the weight for column c. Beat k of a load (k = 0 first) ends up in grid row N-1-k. After N beats, `load_done` is high for exactly one cycle.
- R3: Column result c equals the sum, over rows r, of weight[r][c] times x[r]. Here x[r] is byte r of `act_vec` (bits r*8+7..r*8). The sum is held as a 32-bit two's complement value.
- R4: When `act_signed`=1, both the weights and the vector elements are read as two's complement values in the range -128..127. When `act_signed`=0, both are read as unsigned values in the range 0..255. The mode is taken from the same cycle as the vector.
- R5: Suppose a vector is accepted at clock edge 0 (`act_valid` high at that edge). Then `res_valid[c]` is high for exactly the one cycle that follows edge N+c.
- R6: If `act_accum`=1 with a vector, each column's result is the new sum added to that column's stored value. If `act_accum`=0, the result replaces the stored value. When no result is valid, `res_vec` keeps its last value.
- R7: Vectors accepted on consecutive clocks each produce their own result, in the order they were accepted, with no mixing between waves.
- R8: The weights stay unchanged until the next load, so the same vector sent again gives the same sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_valid | input | 1 | Weight beat present |
| w_row | input | N*8 | One row of weights, byte c for column c |
| w_ready | output | 1 | Weight queue has room |
| load_done | output | 1 | One-cycle pulse once N rows have shifted in |
| act_valid | input | 1 | Activation vector present |
| act_signed | input | 1 | 1: signed operands, 0: unsigned operands |
| act_accum | input | 1 | 1: add into the stored sums, 0: overwrite them |
| act_vec | input | N*8 | Activation vector, byte r for row r |
| res_valid | output | N | Per-column result strobe |
| res_vec | output | N*32 | Per-column accumulator values |

## Verification
Operands of all ones are run in both modes. In unsigned mode this gives the largest possible product, and in signed mode it gives +1 per product, so a mix-up between the two interpretations shows at once. Operands of -128 give the same sum in both modes, which shows that the sign handling stays correct at the end of the range. Random weights, each followed by one isolated vector, expose any error in where a weight row lands and in when each column reports. Long random streams with mixed modes, mixed accumulate flags and random gaps of zero to two cycles show whether back-to-back waves stay separate. Runs of accumulate after an overwrite show whether sums build up across tiles, and a repeated vector shows whether the weights stay fixed.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;

    localparam int DATA_W = 8;
    localparam int SUM_W  = 32;
    localparam int PROD_W = 2 * DATA_W + 2;

    // One lane of an activation wave as it travels right through a grid row.
    typedef struct packed {
        logic              vld;
        logic              sgn;
        logic              acc_add;
        logic [DATA_W-1:0] val;
    } act_pkt_t;

    // Extend both operands to 9 bits (sign or zero), multiply, widen to the sum width.
    function automatic logic [SUM_W-1:0] mac_prod(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] w,
                                                  input logic              sgn);
        logic signed [DATA_W:0]   ae;
        logic signed [DATA_W:0]   we;
        logic signed [PROD_W-1:0] p;
        ae = $signed({sgn & a[DATA_W-1], a});
        we = $signed({sgn & w[DATA_W-1], w});
        p  = ae * we;
        return {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/wsmm_cell.sv
module wsmm_cell
    import wsmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  act_pkt_t          a_in,
    input  logic [SUM_W-1:0]  ps_in,
    input  logic              w_shift,
    input  logic [DATA_W-1:0] w_in,
    output act_pkt_t          a_out,
    output logic [SUM_W-1:0]  ps_out,
    output logic [DATA_W-1:0] w_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out  <= '0;
            ps_out <= '0;
            w_q    <= '0;
        end else begin
            if (w_shift) w_q <= w_in;
            a_out  <= a_in;
            ps_out <= ps_in + mac_prod(a_in.val, w_q, a_in.sgn);
        end
    end

    // R8
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !w_shift |=> $stable(w_q));

endmodule

// File: rtl/wsmm_wfeed.sv
module wsmm_wfeed
    import wsmm_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w_valid,
    input  logic [N*DATA_W-1:0] w_row,
    output logic              w_ready,
    output logic              shift,
    output logic [N*DATA_W-1:0] top_row,
    output logic              load_done
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = $clog2(N + 1);

    logic [N*DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]       wr_ptr, rd_ptr;
    logic [CW-1:0]       count;
    logic [SW-1:0]       shifts;
    logic                push;

    assign w_ready = (count != CW'(DEPTH));
    assign push    = w_valid && w_ready;
    assign shift   = (count != '0);
    assign top_row = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= w_row;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            shifts    <= '0;
            load_done <= 1'b0;
        end else begin
            if (push)  wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (shift) rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(shift);
            load_done <= 1'b0;
            if (shift) begin
                if (shifts == SW'(N-1)) begin
                    shifts    <= '0;
                    load_done <= 1'b1;
                end else begin
                    shifts <= shifts + 1'b1;
                end
            end
        end
    end

    // R2
    load_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R2
    queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/wsmm_accrow.sv
module wsmm_accrow
    import wsmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  act_pkt_t         bot [N],
    input  logic [SUM_W-1:0] ps  [N],
    output logic [N-1:0]     res_valid,
    output logic [N*SUM_W-1:0] res_vec
);

    logic [SUM_W-1:0] acc_q [N];

    for (genvar c = 0; c < N; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[c]     <= '0;
                res_valid[c] <= 1'b0;
            end else begin
                res_valid[c] <= bot[c].vld;
                if (bot[c].vld)
                    acc_q[c] <= bot[c].acc_add ? acc_q[c] + ps[c] : ps[c];
            end
        end
        assign res_vec[c*SUM_W +: SUM_W] = acc_q[c];

        // R6
        acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !bot[c].vld |=> $stable(acc_q[c]));
    end

endmodule

// File: rtl/wsmm_top.sv
module wsmm_top
    import wsmm_pkg::*;
#(
    parameter int N       = 4,
    parameter int WQ_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                w_valid,
    input  logic [N*DATA_W-1:0] w_row,
    output logic                w_ready,
    output logic                load_done,
    input  logic                act_valid,
    input  logic                act_signed,
    input  logic                act_accum,
    input  logic [N*DATA_W-1:0] act_vec,
    output logic [N-1:0]        res_valid,
    output logic [N*SUM_W-1:0]  res_vec
);

    logic                w_shift;
    logic [N*DATA_W-1:0] top_row;

    act_pkt_t         a_h  [N][N+1];
    logic [SUM_W-1:0] ps_v [N+1][N];
    logic [DATA_W-1:0] w_v [N+1][N];
    act_pkt_t         bot  [N];
    logic [SUM_W-1:0] bot_ps [N];

    wsmm_wfeed #(.N(N), .DEPTH(WQ_DEPTH)) u_wfeed (
        .clk       (clk),
        .rst       (rst),
        .w_valid   (w_valid),
        .w_row     (w_row),
        .w_ready   (w_ready),
        .shift     (w_shift),
        .top_row   (top_row),
        .load_done (load_done)
    );

    // Row r of the vector is delayed r clocks before it meets column 0.
    for (genvar r = 0; r < N; r++) begin : g_skew
        act_pkt_t sk [r+1];
        assign sk[0] = '{vld: act_valid, sgn: act_signed, acc_add: act_accum,
                         val: act_vec[r*DATA_W +: DATA_W]};
        for (genvar k = 1; k <= r; k++) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) sk[k] <= '0;
                else     sk[k] <= sk[k-1];
            end
        end
        assign a_h[r][0] = sk[r];
    end

    for (genvar c = 0; c < N; c++) begin : g_edge
        assign ps_v[0][c] = '0;
        assign w_v[0][c]  = top_row[c*DATA_W +: DATA_W];
        assign bot[c]     = a_h[N-1][c+1];
        assign bot_ps[c]  = ps_v[N][c];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            wsmm_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .a_in    (a_h[r][c]),
                .ps_in   (ps_v[r][c]),
                .w_shift (w_shift),
                .w_in    (w_v[r][c]),
                .a_out   (a_h[r][c+1]),
                .ps_out  (ps_v[r+1][c]),
                .w_q     (w_v[r+1][c])
            );
        end
    end

    wsmm_accrow #(.N(N)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .bot       (bot),
        .ps        (bot_ps),
        .res_valid (res_valid),
        .res_vec   (res_vec)
    );

    for (genvar c = 0; c < N-1; c++) begin : g_stagger
        // R5
        col_stagger_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid[c] |=> res_valid[c+1]);
    end

endmodule

// File: tb/wsmm_top_bench.sv
`timescale 1ns/1ps
module wsmm_top_bench;

    localparam int N  = 4;
    localparam int QD = 512;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             w_valid = 1'b0;
    logic [N*8-1:0]   w_row = '0;
    logic             w_ready, load_done;
    logic             act_valid = 1'b0, act_signed = 1'b0, act_accum = 1'b0;
    logic [N*8-1:0]   act_vec = '0;
    logic [N-1:0]     res_valid;
    logic [N*32-1:0]  res_vec;

    always #2 clk = ~clk;

    wsmm_top #(.N(N), .WQ_DEPTH(4)) u_wsmm_top (
        .clk(clk), .rst(rst), .w_valid(w_valid), .w_row(w_row), .w_ready(w_ready),
        .load_done(load_done), .act_valid(act_valid), .act_signed(act_signed),
        .act_accum(act_accum), .act_vec(act_vec), .res_valid(res_valid), .res_vec(res_vec)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] wm [N][N];
    int mdl_acc [N];
    int expq [N][QD];
    int wr_i [N];
    int rd_i [N];
    string tag = "R3";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int ref_dot(input int c, input logic sgn, input logic [N*8-1:0] x);
        int s = 0;
        for (int r = 0; r < N; r++) begin
            int a, w;
            a = sgn ? int'($signed(x[r*8 +: 8])) : int'({24'd0, x[r*8 +: 8]});
            w = sgn ? int'($signed(wm[r][c]))    : int'({24'd0, wm[r][c]});
            s += a * w;
        end
        return s;
    endfunction

    // Result monitor: each strobed column is compared with the next expected value.
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < N; c++) begin
                if (res_valid[c]) begin
                    if (rd_i[c] < wr_i[c]) begin
                        chk(res_vec[c*32 +: 32] == expq[c][rd_i[c] % QD], tag,
                            res_vec[c*32 +: 32], expq[c][rd_i[c] % QD]);
                        rd_i[c]++;
                    end else begin
                        chk(1'b0, "R7 unexpected result", c, -1);
                    end
                end
            end
        end
    end

    // Called right after a negedge: drives one vector for the next edge.
    task automatic put_vec(input logic [N*8-1:0] x, input logic sgn, input logic add);
        act_valid  = 1'b1;
        act_signed = sgn;
        act_accum  = add;
        act_vec    = x;
        for (int c = 0; c < N; c++) begin
            int y;
            y = ref_dot(c, sgn, x);
            mdl_acc[c] = add ? mdl_acc[c] + y : y;
            expq[c][wr_i[c] % QD] = mdl_acc[c];
            wr_i[c]++;
        end
    endtask

    task automatic send_one(input logic [N*8-1:0] x, input logic sgn, input logic add);
        @(negedge clk);
        put_vec(x, sgn, add);
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [N*8-1:0] rnd_vec();
        logic [N*8-1:0] v;
        for (int r = 0; r < N; r++) v[r*8 +: 8] = 8'($urandom_range(0, 255));
        return v;
    endfunction

    // R2: beat k carries grid row N-1-k; load_done must pulse once.
    task automatic load_weights();
        int seen;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            chk(w_ready == 1'b1, "R2 w_ready", int'(w_ready), 1);
            w_valid = 1'b1;
            for (int c = 0; c < N; c++) w_row[c*8 +: 8] = wm[N-1-k][c];
        end
        @(negedge clk);
        w_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 2*N && seen == 0; i++) begin
            if (load_done) seen = 1;
            else @(negedge clk);
        end
        chk(seen == 1, "R2 load_done pulse", seen, 1);
        @(negedge clk);
        chk(load_done == 1'b0, "R2 load_done one cycle", int'(load_done), 0);
        idle(2);
    endtask

    task automatic rnd_weights();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) wm[r][c] = 8'($urandom_range(0, 255));
        load_weights();
    endtask

    task automatic stream(input int count);
        tag = "R7";
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            put_vec(rnd_vec(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 3) == 0) begin
                int gap;
                gap = $urandom_range(1, 2);
                @(negedge clk);
                act_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        act_valid = 1'b0;
        idle(3*N);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < N; c++) begin
            mdl_acc[c] = 0; wr_i[c] = 0; rd_i[c] = 0;
        end
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(res_valid == '0, "R1 res_valid", int'(res_valid), 0);
        chk(res_vec == '0, "R1 res_vec", int'(res_vec[31:0]), 0);
        chk(load_done == 1'b0, "R1 load_done", int'(load_done), 0);
        chk(w_ready == 1'b1, "R1 w_ready", int'(w_ready), 1);

        // R4: all-ones operands, unsigned versus signed
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = 8'hFF;
        load_weights();
        tag = "R4 unsigned 0xFF";
        send_one({N{8'hFF}}, 1'b0, 1'b0);
        idle(2*N + 2);
        tag = "R4 signed 0xFF";
        send_one({N{8'hFF}}, 1'b1, 1'b0);
        idle(2*N + 2);
        // R4: most negative value, identical sum in both modes
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = 8'h80;
        load_weights();
        tag = "R4 signed -128";
        send_one({N{8'h80}}, 1'b1, 1'b0);
        idle(2*N + 2);
        tag = "R4 unsigned 128";
        send_one({N{8'h80}}, 1'b0, 1'b0);
        idle(2*N + 2);

        // R2/R3: row placement with distinct weights; R5 column timing
        rnd_weights();
        tag = "R3 isolated vector";
        @(negedge clk);
        put_vec(rnd_vec(), 1'b0, 1'b0);
        @(negedge clk);
        act_valid = 1'b0;
        for (int m = 0; m < 2*N + 2; m++) begin
            for (int c = 0; c < N; c++)
                chk(res_valid[c] == (m == N + c), "R5 strobe timing",
                    int'(res_valid[c]), int'(m == N + c));
            @(negedge clk);
        end
        idle(2);

        // R6: overwrite then accumulate a tile of four vectors
        tag = "R6 accumulate";
        send_one(rnd_vec(), 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) send_one(rnd_vec(), 1'b1, 1'b1);
        idle(3*N);
        for (int c = 0; c < N; c++)
            chk(res_vec[c*32 +: 32] == mdl_acc[c], "R6 hold", res_vec[c*32 +: 32], mdl_acc[c]);
        tag = "R6 overwrite";
        send_one(rnd_vec(), 1'b0, 1'b0);
        idle(3*N);

        // R8: same vector twice, weights unchanged
        begin
            logic [N*8-1:0] v;
            v = rnd_vec();
            tag = "R8 repeat";
            send_one(v, 1'b1, 1'b0);
            idle(N + 3);
            send_one(v, 1'b1, 1'b0);
            idle(3*N);
        end

        // R7: back-to-back streams, reloading between them
        stream(200);
        rnd_weights();
        stream(150);

        for (int c = 0; c < N; c++)
            chk(rd_i[c] == wr_i[c], "R7 result count", rd_i[c], wr_i[c]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule